// File: doc/BRIEF.md
# TV Sound Mode Matrix Controller

This block holds the decisions of a multichannel TV sound decoder. From three detector flags (stereo pilot present, second-language carrier present, carrier noisy) and a set of control bits, it selects three things. The first is the feed of the noise-reduction expander: nothing, the difference signal or the second-language (SAP) signal. The second is the source of each matrix output channel. The third is the source of the final TV output pair: the decoder matrix, one of two auxiliary stereo inputs, or mute. All analog paths stay outside the block. Its outputs are small select codes that steer external switches.

The detector flags come from analog level detectors and can glitch. Each flag passes through a 2-of-3 vote before use: the current value and the two previous samples. The control bits are used as they arrive. Every select output is a register on the system clock.

Top module: `tv_audio_mode_matrix`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `nr_src`=0, `left_src`=2, `right_src`=2, `tvl_src`=0, `tvr_src`=0, `sap_softmute`=0 and `tv_mute`=1.
- R2: With `sap_req`=0, `force_mono`=0 and the filtered stereo flag 1, the outputs are `nr_src`=1 (difference), `left_src`=0 (left) and `right_src`=1 (right). Codes for `nr_src`: 0 none, 1 difference, 2 SAP. Codes for the channel sources: 0 left, 1 right, 2 sum, 3 SAP.
- R3: With `sap_req`=0, `force_mono`=0 and the filtered stereo flag 0, the outputs are `nr_src`=0 and both channel sources 2 (sum).
- R4: When the SAP path is not chosen and `force_mono`=1, the outputs are `nr_src`=0 and both channel sources 2, whatever the stereo flag says.
- R5: With `sap_any`=1 and `sap_req`=1, `nr_src`=2 whatever the flags say. The channel sources are then 3/3 when `force_mono`=0, and `left_src`=2 with `right_src`=3 when `force_mono`=1.
- R6: With `sap_any`=0 and `sap_req`=1, the SAP path of R5 is chosen only when the filtered SAP flag is 1. Otherwise the outputs follow R2 to R4.
- R7: `sap_softmute` is 1 exactly when the SAP path is chosen and the filtered noise flag is 1.
- R8: With `tv_unmute`=0, `tv_mute`=1 and both TV sources are 0 (mute), whatever `ext_sel`, `aux_sel` and the mono bits say.
- R9: With `tv_unmute`=1 and `ext_sel`=0, `tvl_src`=1 (matrix left) and `tvr_src`=2 (matrix right).
- R10: With `tv_unmute`=1 and `ext_sel`=1, `aux_sel`=0 picks auxiliary 1 and gives codes 3/4. `aux_sel`=1 picks auxiliary 2 and gives codes 5/6. When the mono bit of the selected input is set, both outputs take that input's left code (3/3 or 5/5). The mono bit of the unselected input has no effect.
- R11: A change on a control bit reaches the outputs at the first rising edge. A held change on a detector flag reaches them at the second edge. A detector pulse one cycle long never reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_stereo | input | 1 | Stereo pilot detected |
| det_sap | input | 1 | SAP carrier detected |
| det_noise | input | 1 | SAP carrier noisy |
| sap_req | input | 1 | Request SAP output |
| force_mono | input | 1 | Forced mono / split main-SAP |
| sap_any | input | 1 | Allow SAP output without detection |
| tv_unmute | input | 1 | 1 = TV outputs active |
| ext_sel | input | 1 | 1 = TV outputs from auxiliary input |
| aux_sel | input | 1 | 0 = auxiliary 1, 1 = auxiliary 2 |
| aux1_mono | input | 1 | Auxiliary 1 forced mono |
| aux2_mono | input | 1 | Auxiliary 2 forced mono |
| nr_src | output | 2 | Expander input select |
| left_src | output | 2 | Matrix left source |
| right_src | output | 2 | Matrix right source |
| tvl_src | output | 3 | TV left source |
| tvr_src | output | 3 | TV right source |
| sap_softmute | output | 1 | SAP soft-mute request |
| tv_mute | output | 1 | TV outputs muted |

## Verification
The bench targets three corner cases. In the first, SAP is requested without detection under both settings of `sap_any`: a design that mixes up the two settings either plays silent SAP or refuses a forced one. In the second, noise is present while the SAP path is idle: a design that ignores the gating would soft-mute stereo. In the third, the mono bit of the unselected auxiliary input is set: a design that ORs the two bits collapses the wrong input. The bench also checks the exact latency of a control change and of a held flag change, and it checks that a one-cycle flag glitch leaves the outputs untouched. A filter that is too weak or too slow shows up at once in these checks.

// File: rtl/tv_audio_mode_matrix.sv
module tv_audio_mode_matrix #(
  parameter int NFLAG = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_stereo,
  input  logic       det_sap,
  input  logic       det_noise,
  input  logic       sap_req,
  input  logic       force_mono,
  input  logic       sap_any,
  input  logic       tv_unmute,
  input  logic       ext_sel,
  input  logic       aux_sel,
  input  logic       aux1_mono,
  input  logic       aux2_mono,
  output logic [1:0] nr_src,
  output logic [1:0] left_src,
  output logic [1:0] right_src,
  output logic [2:0] tvl_src,
  output logic [2:0] tvr_src,
  output logic       sap_softmute,
  output logic       tv_mute
);
  localparam logic [1:0] NR_NONE = 2'd0, NR_DIFF = 2'd1, NR_SAP = 2'd2;
  localparam logic [1:0] CH_L = 2'd0, CH_R = 2'd1, CH_SUM = 2'd2, CH_SAP = 2'd3;
  localparam logic [2:0] TV_MUTE = 3'd0, TV_ML = 3'd1, TV_MR = 3'd2,
                         TV_A1L = 3'd3, TV_A1R = 3'd4, TV_A2L = 3'd5, TV_A2R = 3'd6;

  logic [NFLAG-1:0] raw, h0, h1, flt;
  assign raw = {det_noise, det_sap, det_stereo};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h0 <= '0;
      h1 <= '0;
    end else begin
      h0 <= raw;
      h1 <= h0;
    end

  for (genvar i = 0; i < NFLAG; i++) begin : g_vote
    assign flt[i] = (raw[i] & h0[i]) | (raw[i] & h1[i]) | (h0[i] & h1[i]);
  end

  logic st_f, sap_f, noise_f, sap_path;
  assign st_f     = flt[0];
  assign sap_f    = flt[1];
  assign noise_f  = flt[2];
  assign sap_path = sap_req & (sap_any | sap_f);

  logic [1:0] nr_d, l_d, r_d;
  always_comb begin
    if (sap_path) begin
      nr_d = NR_SAP;
      l_d  = force_mono ? CH_SUM : CH_SAP;
      r_d  = CH_SAP;
    end else if (st_f && !force_mono) begin
      nr_d = NR_DIFF;
      l_d  = CH_L;
      r_d  = CH_R;
    end else begin
      nr_d = NR_NONE;
      l_d  = CH_SUM;
      r_d  = CH_SUM;
    end
  end

  logic [2:0] tl_d, tr_d;
  logic       mono_sel;
  assign mono_sel = aux_sel ? aux2_mono : aux1_mono;

  always_comb begin
    if (!tv_unmute) begin
      tl_d = TV_MUTE;
      tr_d = TV_MUTE;
    end else if (!ext_sel) begin
      tl_d = TV_ML;
      tr_d = TV_MR;
    end else begin
      tl_d = aux_sel ? TV_A2L : TV_A1L;
      tr_d = mono_sel ? tl_d : (aux_sel ? TV_A2R : TV_A1R);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nr_src       <= NR_NONE;
      left_src     <= CH_SUM;
      right_src    <= CH_SUM;
      tvl_src      <= TV_MUTE;
      tvr_src      <= TV_MUTE;
      sap_softmute <= 1'b0;
      tv_mute      <= 1'b1;
    end else begin
      nr_src       <= nr_d;
      left_src     <= l_d;
      right_src    <= r_d;
      tvl_src      <= tl_d;
      tvr_src      <= tr_d;
      sap_softmute <= sap_path & noise_f;
      tv_mute      <= ~tv_unmute;
    end
endmodule

// File: rtl/tv_audio_mode_matrix_chk.sv
module tv_audio_mode_matrix_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sap_req,
  input logic       force_mono,
  input logic       sap_any,
  input logic       tv_unmute,
  input logic       ext_sel,
  input logic       aux_sel,
  input logic       aux1_mono,
  input logic       aux2_mono,
  input logic [1:0] nr_src,
  input logic [1:0] left_src,
  input logic [1:0] right_src,
  input logic [2:0] tvl_src,
  input logic [2:0] tvr_src,
  input logic       sap_softmute,
  input logic       tv_mute
);
  assert_legal_nr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nr_src != 2'd3);
  assert_idle_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_src == 2'd0) |-> (left_src == 2'd2 && right_src == 2'd2));
  assert_mono_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_mono && !sap_req) |=> (nr_src == 2'd0 && left_src == 2'd2 && right_src == 2'd2));
  assert_forced_sap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sap_req && sap_any) |=> (nr_src == 2'd2 && right_src == 2'd3));
  assert_softmute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sap_softmute |-> (nr_src == 2'd2));
  assert_tv_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tv_unmute |=> (tv_mute && tvl_src == 3'd0 && tvr_src == 3'd0));
  assert_tv_matrix_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tv_unmute && !ext_sel) |=> (!tv_mute && tvl_src == 3'd1 && tvr_src == 3'd2));
  assert_aux1_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tv_unmute && ext_sel && !aux_sel && aux1_mono) |=> (tvl_src == 3'd3 && tvr_src == 3'd3));
  assert_aux2_stereo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tv_unmute && ext_sel && aux_sel && !aux2_mono) |=> (tvl_src == 3'd5 && tvr_src == 3'd6));
endmodule

bind tv_audio_mode_matrix tv_audio_mode_matrix_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sap_req(sap_req), .force_mono(force_mono),
  .sap_any(sap_any), .tv_unmute(tv_unmute), .ext_sel(ext_sel), .aux_sel(aux_sel),
  .aux1_mono(aux1_mono), .aux2_mono(aux2_mono), .nr_src(nr_src),
  .left_src(left_src), .right_src(right_src), .tvl_src(tvl_src),
  .tvr_src(tvr_src), .sap_softmute(sap_softmute), .tv_mute(tv_mute)
);

// File: tb/tb_tv_audio_mode_matrix.sv
module tb_tv_audio_mode_matrix;
  logic clk = 1'b0, rst_n = 1'b0;
  logic det_stereo = 0, det_sap = 0, det_noise = 0;
  logic sap_req = 0, force_mono = 0, sap_any = 0, tv_unmute = 0;
  logic ext_sel = 0, aux_sel = 0, aux1_mono = 0, aux2_mono = 0;
  logic [1:0] nr_src, left_src, right_src;
  logic [2:0] tvl_src, tvr_src;
  logic sap_softmute, tv_mute;

  always #2 clk = ~clk;

  tv_audio_mode_matrix dut (.*);

  int checks = 0, failures = 0;
  logic [13:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  function automatic logic [13:0] ex(int nr, int l, int r, int tl, int tr, int sm, int tm);
    return {nr[1:0], l[1:0], r[1:0], tl[2:0], tr[2:0], sm[0], tm[0]};
  endfunction

  function automatic logic [13:0] got();
    return {nr_src, left_src, right_src, tvl_src, tvr_src, sap_softmute, tv_mute};
  endfunction

  task automatic compare(logic [13:0] e, string tag);
    checks++;
    if (got() !== e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, got(), e);
    end
  endtask

  // inputs: st sap noise req mono any unmute ext aux m1 m2
  task automatic put(logic [10:0] v);
    {det_stereo, det_sap, det_noise, sap_req, force_mono, sap_any,
     tv_unmute, ext_sel, aux_sel, aux1_mono, aux2_mono} = v;
  endtask

  task automatic settle(logic [10:0] v, logic [13:0] e, string tag);
    @(negedge clk); put(v);
    repeat (2) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic push_now(logic [13:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(ex(0,2,2,0,0,0,1), "R1 reset");
    rst_n = 1'b1;
    settle(11'b100_000_1_0_0_0_0, ex(1,0,1,1,2,0,0), "R2 stereo / R9 matrix");
    settle(11'b000_000_1_0_0_0_0, ex(0,2,2,1,2,0,0), "R3 mono");
    settle(11'b100_010_1_0_0_0_0, ex(0,2,2,1,2,0,0), "R4 forced mono on stereo");
    settle(11'b000_101_1_0_0_0_0, ex(2,3,3,1,2,0,0), "R5 forced SAP no detect");
    settle(11'b000_111_1_0_0_0_0, ex(2,2,3,1,2,0,0), "R5 split main/SAP");
    settle(11'b100_101_1_0_0_0_0, ex(2,3,3,1,2,0,0), "R5 forced SAP over stereo");
    settle(11'b100_100_1_0_0_0_0, ex(1,0,1,1,2,0,0), "R6 no SAP -> stereo");
    settle(11'b000_100_1_0_0_0_0, ex(0,2,2,1,2,0,0), "R6 no SAP -> mono");
    settle(11'b010_100_1_0_0_0_0, ex(2,3,3,1,2,0,0), "R6 SAP detected");
    settle(11'b010_110_1_0_0_0_0, ex(2,2,3,1,2,0,0), "R6 SAP detected split");
    settle(11'b011_100_1_0_0_0_0, ex(2,3,3,1,2,1,0), "R7 noisy SAP");
    settle(11'b101_000_1_0_0_0_0, ex(1,0,1,1,2,0,0), "R7 noise without SAP path");
    settle(11'b001_101_1_0_0_0_0, ex(2,3,3,1,2,1,0), "R7 noisy forced SAP");
    settle(11'b100_000_0_0_0_0_0, ex(1,0,1,0,0,0,1), "R8 TV mute");
    settle(11'b100_000_0_1_1_1_1, ex(1,0,1,0,0,0,1), "R8 TV mute over aux");
    settle(11'b000_000_1_1_0_0_0, ex(0,2,2,3,4,0,0), "R10 aux1 stereo");
    settle(11'b000_000_1_1_0_1_0, ex(0,2,2,3,3,0,0), "R10 aux1 mono");
    settle(11'b000_000_1_1_0_0_1, ex(0,2,2,3,4,0,0), "R10 aux2 mono bit ignored");
    settle(11'b000_000_1_1_1_0_0, ex(0,2,2,5,6,0,0), "R10 aux2 stereo");
    settle(11'b000_000_1_1_1_0_1, ex(0,2,2,5,5,0,0), "R10 aux2 mono");
    settle(11'b000_000_1_1_1_1_0, ex(0,2,2,5,6,0,0), "R10 aux1 mono bit ignored");
    // R11 control latency: one edge
    settle(11'b100_000_1_0_0_0_0, ex(1,0,1,1,2,0,0), "R11 setup");
    @(negedge clk); force_mono = 1; push_now(ex(0,2,2,1,2,0,0), "R11 control one edge");
    // R11 held flag: two edges
    settle(11'b000_000_1_0_0_0_0, ex(0,2,2,1,2,0,0), "R11 setup flag");
    @(negedge clk); det_stereo = 1; push_now(ex(0,2,2,1,2,0,0), "R11 flag first edge");
    @(negedge clk); push_now(ex(1,0,1,1,2,0,0), "R11 flag second edge");
    // R11 one-cycle glitch
    settle(11'b000_000_1_0_0_0_0, ex(0,2,2,1,2,0,0), "R11 setup glitch");
    @(negedge clk); det_stereo = 1; push_now(ex(0,2,2,1,2,0,0), "R11 glitch a");
    @(negedge clk); det_stereo = 0; push_now(ex(0,2,2,1,2,0,0), "R11 glitch b");
    @(negedge clk); push_now(ex(0,2,2,1,2,0,0), "R11 glitch c");
    @(negedge clk); push_now(ex(0,2,2,1,2,0,0), "R11 glitch d");
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule